// File: doc/BRIEF.md
# Single-Master Memory Map Router

This block sits between one bus master and four slaves. The bus has a request channel and a response channel, each with its own valid/ready handshake. For each request the router looks at the byte address and picks the boot region, the MMIO window, the instruction RAM or the data RAM. It forwards the request fields to that slave unchanged. It then passes the slave's response back to the master and leaves each slave's ready signal under the control of the master.

Some requests must not reach any slave: addresses outside the four windows, accesses that are not aligned to their size, and the unused size code. The router answers these itself with an error response, so no slave sees them.

The router allows only one transaction in flight. A new request is taken only after the master has accepted the response to the previous one. This keeps the response ordering trivial, whatever latency each slave has.

Top module: `bus_addr_router`

## Requirements
- R1: Byte addresses 0x0000_0000 through 0x00FF_FFFF go to slave index 0 (boot).
- R2: Byte addresses 0x1000_0000 through 0x1000_0FFF go to slave index 1 (MMIO).
- R3: Byte addresses 0x2000_0000 through 0x2000_FFFF go to slave index 2 (instruction RAM).
- R4: Byte addresses 0x8000_0000 through 0x8000_FFFF go to slave index 3 (data RAM).
- R5: A request whose address lies in none of these windows gets an error response and raises no slave's request valid. This includes the rest of the boot aperture, 0x0100_0000 through 0x0FFF_FFFF.
- R6: Size encoding is 00 byte, 01 halfword, 10 word. A halfword at an odd address, a word whose address has either low bit set, and size code 11 each get an error response, and no slave is requested.
- R7: A router-generated error response shows valid, error flag 1 and read data 0 in the cycle after the request is accepted. It stays valid until the master takes it.
- R8: Once a request is accepted, the master's request ready stays low until that transaction's response has been accepted.
- R9: A slave's read data and error flag reach the master unchanged, and that slave's response ready follows the master's response ready.
- R10: A routed request raises exactly one slave's request valid, carrying the address, write flag, size, write data and byte strobe unchanged.
- R11: After reset no response is valid and no slave request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Router accepts the master request |
| m_req_addr | input | ADDR_W | Byte address |
| m_req_we | input | 1 | 1 = write, 0 = read |
| m_req_size | input | 2 | Access size code |
| m_req_wdata | input | DATA_W | Write data |
| m_req_wstrb | input | DATA_W/8 | Byte strobes |
| m_rsp_valid | output | 1 | Response valid to master |
| m_rsp_ready | input | 1 | Master accepts response |
| m_rsp_rdata | output | DATA_W | Response read data |
| m_rsp_err | output | 1 | Response error flag |
| s_req_valid | output | 4 | Per-slave request valid |
| s_req_ready | input | 4 | Per-slave request ready |
| s_req_addr | output | ADDR_W | Forwarded address |
| s_req_we | output | 1 | Forwarded write flag |
| s_req_size | output | 2 | Forwarded size |
| s_req_wdata | output | DATA_W | Forwarded write data |
| s_req_wstrb | output | DATA_W/8 | Forwarded strobes |
| s_rsp_valid | input | 4 | Per-slave response valid |
| s_rsp_ready | output | 4 | Per-slave response ready |
| s_rsp_rdata | input | 4*DATA_W | Per-slave read data, slave i in bits i*DATA_W upward |
| s_rsp_err | input | 4 | Per-slave error flag |

## Verification
Addresses are sent at both edges of each window and just past each edge. The in-window cases check that the right slave is chosen; the out-of-window cases, including the unused part of the boot aperture, check that the decoder errors instead of rounding into a neighbouring window. Each size code is tried at aligned and unaligned offsets, which separates the alignment check from the address decode. Slaves with different latencies, combined with a master that stalls the response, show whether read data, the error flag and the one-outstanding rule survive backpressure.

// File: rtl/bus_router_pkg.sv
package bus_router_pkg;
  localparam int NSLV = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_ERR  = 2'd2
  } phase_e;

  // Window base and log2 span per slave index: boot, mmio, instr RAM, data RAM
  localparam logic [31:0] WIN_BASE [NSLV] = '{32'h0000_0000, 32'h1000_0000,
                                              32'h2000_0000, 32'h8000_0000};
  localparam int WIN_LOG2 [NSLV] = '{24, 12, 16, 16};
endpackage

// File: rtl/route_decode.sv
module route_decode
  import bus_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = $clog2(NSLV)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [SEL_W-1:0]  sel,
  output logic              bad_align,
  output logic              dec_err
);
  logic [NSLV-1:0] hit;

  for (genvar g = 0; g < NSLV; g++) begin : g_win
    localparam logic [ADDR_W-1:0] MASK =
      ~((ADDR_W'(1) << WIN_LOG2[g]) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE[g]);
    assign hit[g] = (addr & MASK) == BASE;
  end

  always_comb begin
    sel = '0;
    for (int i = NSLV - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i);
    end
  end

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: bad_align = 1'b0;
      SZ_HALF: bad_align = addr[0];
      SZ_WORD: bad_align = |addr[1:0];
      default: bad_align = 1'b1;
    endcase
  end

  assign dec_err = bad_align || (hit == '0);
endmodule

// File: rtl/route_tracker.sv
module route_tracker
  import bus_router_pkg::*;
#(
  parameter int SEL_W = $clog2(NSLV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             m_req_valid,
  input  logic             dec_err,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSLV-1:0]  s_req_ready,
  input  logic             rsp_fire,
  output logic             m_req_ready,
  output logic [NSLV-1:0]  s_req_valid,
  output phase_e           phase,
  output logic [SEL_W-1:0] sel_q
);
  phase_e ph_q;
  logic   accept;

  always_comb begin
    s_req_valid = '0;
    m_req_ready = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (dec_err) begin
        m_req_ready = 1'b1;
      end else begin
        s_req_valid[sel] = m_req_valid;
        m_req_ready      = s_req_ready[sel];
      end
    end
  end

  assign accept = m_req_valid && m_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      sel_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (accept) begin
          ph_q  <= dec_err ? PH_ERR : PH_WAIT;
          sel_q <= sel;
        end
        PH_WAIT: if (rsp_fire) ph_q <= PH_IDLE;
        PH_ERR:  if (rsp_fire) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = ph_q;

  // R8: no second request is taken right after one is accepted
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !m_req_ready);
endmodule

// File: rtl/route_rsp_mux.sv
module route_rsp_mux
  import bus_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(NSLV)
) (
  input  phase_e                 phase,
  input  logic [SEL_W-1:0]       sel_q,
  input  logic [NSLV-1:0]        s_rsp_valid,
  input  logic [NSLV*DATA_W-1:0] s_rsp_rdata,
  input  logic [NSLV-1:0]        s_rsp_err,
  input  logic                   m_rsp_ready,
  output logic                   m_rsp_valid,
  output logic [DATA_W-1:0]      m_rsp_rdata,
  output logic                   m_rsp_err,
  output logic [NSLV-1:0]        s_rsp_ready
);
  always_comb begin
    m_rsp_valid = 1'b0;
    m_rsp_rdata = '0;
    m_rsp_err   = 1'b0;
    s_rsp_ready = '0;
    case (phase)
      PH_WAIT: begin
        m_rsp_valid        = s_rsp_valid[sel_q];
        m_rsp_rdata        = s_rsp_rdata[sel_q*DATA_W +: DATA_W];
        m_rsp_err          = s_rsp_err[sel_q];
        s_rsp_ready[sel_q] = m_rsp_ready;
      end
      PH_ERR: begin
        m_rsp_valid = 1'b1;
        m_rsp_err   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_addr_router.sv
module bus_addr_router
  import bus_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   m_req_valid,
  output logic                   m_req_ready,
  input  logic [ADDR_W-1:0]      m_req_addr,
  input  logic                   m_req_we,
  input  logic [1:0]             m_req_size,
  input  logic [DATA_W-1:0]      m_req_wdata,
  input  logic [DATA_W/8-1:0]    m_req_wstrb,
  output logic                   m_rsp_valid,
  input  logic                   m_rsp_ready,
  output logic [DATA_W-1:0]      m_rsp_rdata,
  output logic                   m_rsp_err,
  output logic [NSLV-1:0]        s_req_valid,
  input  logic [NSLV-1:0]        s_req_ready,
  output logic [ADDR_W-1:0]      s_req_addr,
  output logic                   s_req_we,
  output logic [1:0]             s_req_size,
  output logic [DATA_W-1:0]      s_req_wdata,
  output logic [DATA_W/8-1:0]    s_req_wstrb,
  input  logic [NSLV-1:0]        s_rsp_valid,
  output logic [NSLV-1:0]        s_rsp_ready,
  input  logic [NSLV*DATA_W-1:0] s_rsp_rdata,
  input  logic [NSLV-1:0]        s_rsp_err
);
  localparam int SEL_W = $clog2(NSLV);

  logic [SEL_W-1:0] sel, sel_q;
  logic             bad_align, dec_err;
  phase_e           phase;

  assign s_req_addr  = m_req_addr;
  assign s_req_we    = m_req_we;
  assign s_req_size  = m_req_size;
  assign s_req_wdata = m_req_wdata;
  assign s_req_wstrb = m_req_wstrb;

  route_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) dec_i (
    .addr(m_req_addr), .size(m_req_size), .sel(sel),
    .bad_align(bad_align), .dec_err(dec_err)
  );

  route_tracker #(.SEL_W(SEL_W)) trk_i (
    .clk(clk), .rst(rst), .m_req_valid(m_req_valid), .dec_err(dec_err),
    .sel(sel), .s_req_ready(s_req_ready),
    .rsp_fire(m_rsp_valid && m_rsp_ready),
    .m_req_ready(m_req_ready), .s_req_valid(s_req_valid),
    .phase(phase), .sel_q(sel_q)
  );

  route_rsp_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) mux_i (
    .phase(phase), .sel_q(sel_q), .s_rsp_valid(s_rsp_valid),
    .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err),
    .m_rsp_ready(m_rsp_ready), .m_rsp_valid(m_rsp_valid),
    .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err),
    .s_rsp_ready(s_rsp_ready)
  );

  p_err_no_slave_r5: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && dec_err) |-> (s_req_valid == '0));

  p_misalign_no_slave_r6: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && bad_align) |-> (s_req_valid == '0));

  p_err_next_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && m_req_ready && dec_err) |=>
      (m_rsp_valid && m_rsp_err && m_rsp_rdata == '0));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (m_rsp_valid && m_rsp_err && s_rsp_valid == '0 && !m_rsp_ready) |=> m_rsp_valid);

  p_rsp_from_slave_r9: assert property (@(posedge clk) disable iff (rst)
    (m_rsp_valid && !m_rsp_err) |-> (s_rsp_valid != '0));

  p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && m_req_ready && !dec_err) |-> ($countones(s_req_valid) == 1));
endmodule

// File: tb/bus_addr_router_tb_top.sv
module stub_slave #(
  parameter int LAT = 1,
  parameter int IDX = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);
  logic        busy;
  int          cnt;
  logic [31:0] a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cnt <= 0; a_q <= '0;
    end else if (!busy) begin
      if (req_valid && req_ready) begin
        busy <= 1'b1; cnt <= LAT - 1; a_q <= req_addr;
      end
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end else if (rsp_ready) begin
      busy <= 1'b0;
    end
  end

  assign req_ready = !busy;
  assign rsp_valid = busy && (cnt == 0);
  assign rsp_rdata = a_q ^ (32'(IDX) << 30);
  assign rsp_err   = (a_q[7:0] == 8'hFC);
endmodule

module bus_addr_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req_valid = 1'b0;
  logic        m_req_ready;
  logic [31:0] m_req_addr = '0;
  logic        m_req_we = 1'b0;
  logic [1:0]  m_req_size = 2'b00;
  logic [31:0] m_req_wdata = '0;
  logic [3:0]  m_req_wstrb = '0;
  logic        m_rsp_valid;
  logic        m_rsp_ready = 1'b0;
  logic [31:0] m_rsp_rdata;
  logic        m_rsp_err;
  logic [3:0]  s_req_valid, s_req_ready, s_rsp_valid, s_rsp_ready, s_rsp_err;
  logic [31:0] s_req_addr, s_req_wdata;
  logic        s_req_we;
  logic [1:0]  s_req_size;
  logic [3:0]  s_req_wstrb;
  logic [127:0] s_rsp_rdata;
  logic [31:0] stub_rdata [4];

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic [31:0] q_rdata [$];
  logic        q_err   [$];
  int          q_first [$];
  int          q_stall [$];
  string       q_req   [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_addr_router dut_i (
    .clk(clk), .rst(rst),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
    .m_req_addr(m_req_addr), .m_req_we(m_req_we), .m_req_size(m_req_size),
    .m_req_wdata(m_req_wdata), .m_req_wstrb(m_req_wstrb),
    .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready),
    .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
    .s_req_addr(s_req_addr), .s_req_we(s_req_we), .s_req_size(s_req_size),
    .s_req_wdata(s_req_wdata), .s_req_wstrb(s_req_wstrb),
    .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
    .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err)
  );

  for (genvar g = 0; g < 4; g++) begin : g_stub
    stub_slave #(.LAT(g + 1), .IDX(g)) stub_i (
      .clk(clk), .rst(rst),
      .req_valid(s_req_valid[g]), .req_ready(s_req_ready[g]),
      .req_addr(s_req_addr),
      .rsp_valid(s_rsp_valid[g]), .rsp_ready(s_rsp_ready[g]),
      .rsp_rdata(stub_rdata[g]), .rsp_err(s_rsp_err[g])
    );
  end
  assign s_rsp_rdata = {stub_rdata[3], stub_rdata[2], stub_rdata[1], stub_rdata[0]};

  task automatic check(input logic ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Driver: issue one request, check routing, push the expected response
  task automatic send(input logic [31:0] a, input logic we, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [3:0] ws,
                      input int slv, input int stall, input string rq);
    @(negedge clk);
    m_req_addr = a; m_req_we = we; m_req_size = sz;
    m_req_wdata = wd; m_req_wstrb = ws; m_req_valid = 1'b1;
    #1;
    while (!m_req_ready) begin
      @(negedge clk); #1;
    end
    if (slv < 0) begin
      check(s_req_valid == 4'b0000, rq, 64'(s_req_valid), 64'h0);
      q_rdata.push_back(32'h0); q_err.push_back(1'b1);
      q_first.push_back(cyc + 1);
    end else begin
      check(s_req_valid == 4'(1 << slv), rq, 64'(s_req_valid), 64'(1 << slv));
      check({s_req_addr, s_req_wdata} == {a, wd} &&
            {s_req_we, s_req_size, s_req_wstrb} == {we, sz, ws}, "R10",
            {s_req_addr, s_req_wdata}, {a, wd});
      q_rdata.push_back(a ^ (32'(slv) << 30));
      q_err.push_back(a[7:0] == 8'hFC);
      q_first.push_back(-1);
    end
    q_stall.push_back(stall);
    q_req.push_back(rq);
    @(posedge clk);
    @(negedge clk);
    m_req_valid = 1'b0;
    #1;
    check(!m_req_ready, "R8", 64'(m_req_ready), 64'h0);
  endtask

  // Monitor: drive response ready, compare against queue head
  bit seen = 1'b0;
  int stall_left = 0;
  always begin
    @(negedge clk); #2;
    if (rst) begin
      m_rsp_ready = 1'b0;
    end else if (m_rsp_valid) begin
      if (q_rdata.size() == 0) begin
        check(1'b0, "R9 unexpected response", 64'(m_rsp_rdata), 64'h0);
        m_rsp_ready = 1'b1;
      end else begin
        if (!seen) begin
          seen = 1'b1;
          stall_left = q_stall[0];
          if (q_first[0] >= 0)
            check(cyc == q_first[0], "R7 latency", 64'(cyc), 64'(q_first[0]));
        end
        if (stall_left > 0) begin
          m_rsp_ready = 1'b0;
          stall_left--;
        end else begin
          m_rsp_ready = 1'b1;
          check(m_rsp_rdata == q_rdata[0], q_req[0], 64'(m_rsp_rdata), 64'(q_rdata[0]));
          check(m_rsp_err == q_err[0], "R9 err flag", 64'(m_rsp_err), 64'(q_err[0]));
          void'(q_rdata.pop_front()); void'(q_err.pop_front());
          void'(q_first.pop_front()); void'(q_stall.pop_front());
          void'(q_req.pop_front());
          seen = 1'b0;
        end
      end
    end else begin
      m_rsp_ready = 1'b0;
      if (seen) begin
        check(1'b0, "R7 response dropped before accept", 64'h0, 64'h1);
        seen = 1'b0;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(m_rsp_valid == 1'b0, "R11", 64'(m_rsp_valid), 64'h0);
    check(s_req_valid == 4'b0000, "R11", 64'(s_req_valid), 64'h0);

    // In-window, both window edges
    send(32'h0000_0000, 1'b0, 2'b10, 32'h0, 4'h0, 0, 0, "R1 boot low");
    send(32'h00FF_FFFC, 1'b0, 2'b10, 32'h0, 4'h0, 0, 2, "R1 boot high");
    send(32'h1000_0000, 1'b1, 2'b10, 32'hDEAD_BEEF, 4'hF, 1, 0, "R2 mmio low");
    send(32'h1000_0FFF, 1'b1, 2'b00, 32'h0000_00AB, 4'h8, 1, 3, "R2 mmio high");
    send(32'h2000_0000, 1'b0, 2'b10, 32'h0, 4'h0, 2, 0, "R3 imem low");
    send(32'h2000_FFFE, 1'b0, 2'b01, 32'h0, 4'h0, 2, 1, "R3 imem high");
    send(32'h8000_0000, 1'b1, 2'b10, 32'h1234_5678, 4'hF, 3, 0, "R4 dmem low");
    send(32'h8000_FFFF, 1'b0, 2'b00, 32'h0, 4'h0, 3, 0, "R4 dmem high");
    send(32'h8000_01FC, 1'b0, 2'b10, 32'h0, 4'h0, 3, 2, "R9 slave error");
    send(32'h8000_0002, 1'b1, 2'b01, 32'h5555_0000, 4'hC, 3, 0, "R6 aligned half");

    // Just outside each window
    send(32'h0100_0000, 1'b0, 2'b10, 32'h0, 4'h0, -1, 0, "R5 upper aperture");
    send(32'h0FFF_FFF0, 1'b0, 2'b10, 32'h0, 4'h0, -1, 2, "R5 aperture top");
    send(32'h1000_1000, 1'b0, 2'b10, 32'h0, 4'h0, -1, 0, "R5 past mmio");
    send(32'h0FFF_FFFC, 1'b1, 2'b10, 32'h0, 4'hF, -1, 0, "R5 below mmio");
    send(32'h2001_0000, 1'b0, 2'b10, 32'h0, 4'h0, -1, 0, "R5 past imem");
    send(32'h7FFF_FFFC, 1'b0, 2'b10, 32'h0, 4'h0, -1, 0, "R5 below dmem");
    send(32'h8001_0000, 1'b0, 2'b10, 32'h0, 4'h0, -1, 1, "R5 past dmem");
    send(32'hFFFF_FFFC, 1'b0, 2'b10, 32'h0, 4'h0, -1, 0, "R5 top");

    // Misaligned and reserved size inside mapped windows
    send(32'h8000_0001, 1'b0, 2'b01, 32'h0, 4'h0, -1, 0, "R6 odd half");
    send(32'h2000_0002, 1'b0, 2'b10, 32'h0, 4'h0, -1, 3, "R6 word off2");
    send(32'h1000_0001, 1'b1, 2'b10, 32'h0, 4'hF, -1, 0, "R6 word off1");
    send(32'h8000_0000, 1'b0, 2'b11, 32'h0, 4'h0, -1, 0, "R6 size 11");
    send(32'h0000_0003, 1'b0, 2'b00, 32'h0, 4'h0, 0, 0, "R1 byte odd ok");

    while (q_rdata.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R8: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule